// File: doc/BRIEF.md
# Handshaked Byte Transfer Engine

This block moves packet bytes across an 8-bit shift-data register between a host and a peripheral controller. The exchange is paced by three active-low lines in a port-B register. The host drives the transfer-in-progress line (TIP) and the acknowledge line (TACK). The engine drives the request line (TREQ) back to the host. One bit of a control register sets the direction. Every byte step, and every end of a transfer, raises a shift flag that the host clears explicitly.

When the host sends, each shift-data byte that is present at a handshake edge is appended to a capture buffer. When TIP returns high, the captured length is reported as a one-cycle packet strobe. The device side fills a response buffer and commits it with a length. The engine then pulls TREQ low and hands the bytes out one per handshake edge. It lets TREQ go high once the last byte is in the shift register.

The engine is evaluated in a three-state machine. The state records how the previous evaluation left TIP. `HS_IDLE` means TIP was high. `HS_SEND` means TIP was low with the direction set to host-to-device. `HS_RECV` means TIP was low with the direction set to device-to-host. The transitions are:
- to_idle: any evaluation with TIP high.
- to_send: an evaluation with TIP low and the direction bit at 1.
- to_recv: an evaluation with TIP low and the direction bit at 0.

After reset the machine is in `HS_RECV`, because all port-B bits are reset to 0. An evaluation happens in any cycle with a port-B write, a control write or a response commit.

Top module: `hte_engine`

## Requirements
- R1: Reset sets port B, the control register, the shift data, the shift flag, the packet strobe and all buffer counts and indices to 0.
- R2: Port B bit 5 is TIP, bit 4 is TACK and bit 3 is TREQ, all active low; a transfer is active while bit 5 is 0, and control bit 4 selects host-to-device (1) or device-to-host (0).
- R3: While active in host-to-device direction, an evaluation whose {TACK,TIP} pair differs from the previous evaluation appends the shift-data byte to the capture buffer and sets the shift flag; an unchanged pair moves nothing and leaves the flag alone.
- R4: The capture buffer holds CAP_DEPTH bytes; a byte offered when it is full is dropped and does not set the flag.
- R5: While active in device-to-host direction with unread response bytes, a {TACK,TIP} change loads the next response byte into the shift data and sets the flag; loading the last byte drives TREQ (bit 3) to 1; with no unread bytes nothing moves.
- R6: With TIP high now and at the previous evaluation, a change of TACK copies the new TACK level into TREQ and sets the flag.
- R7: An evaluation that sees TIP high after an active one always sets the flag; if bytes were captured it raises pkt_valid for one cycle with pkt_len equal to the count and clears the count, otherwise no strobe.
- R8: An idle evaluation that does not take the R6 path drives TREQ to 0 whenever unread response bytes remain.
- R9: A response commit sets the length, restarts the read index at 0, performs an evaluation and sets the flag.
- R10: shift_clr clears the flag, but a flag set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_wr_en | input | 1 | Write strobe for port B |
| pb_wr_data | input | 8 | Port B write value |
| pb_q | output | 8 | Port B register (TREQ as driven by the engine) |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 8 | Control write value (bit 4 = direction) |
| ctl_q | output | 8 | Control register |
| sd_wr_en | input | 1 | Host write of the shift data register |
| sd_wr_data | input | 8 | Shift data write value |
| sd_q | output | 8 | Shift data register |
| shift_clr | input | 1 | Clear the shift flag |
| shift_flag | output | 1 | Shift interrupt request flag |
| rsp_wr_en | input | 1 | Response buffer write strobe |
| rsp_wr_addr | input | RSP_AW | Response buffer write address |
| rsp_wr_data | input | 8 | Response buffer write byte |
| rsp_load | input | 1 | Commit a response packet |
| rsp_len | input | LEN_W | Committed response length (at most RSP_DEPTH) |
| cap_rd_addr | input | CAP_AW | Capture buffer read address |
| cap_rd_data | output | 8 | Capture buffer byte at cap_rd_addr (combinational) |
| pkt_valid | output | 1 | One-cycle end-of-packet strobe |
| pkt_len | output | CNT_W | Byte count of the finished packet |

## Verification
The bench builds the block with its default depths: a 16-byte capture buffer and a 128-byte response buffer. A 16-entry capture buffer is small enough for a directed loop to fill it and push a seventeenth byte. That loop shows the drop and the missing flag at the full boundary. A three-byte response puts the last-byte TREQ release and the empty-buffer hold within a handful of handshake edges.

// File: rtl/hte_pkg.sv
package hte_pkg;
    localparam int TREQ_BIT = 3;
    localparam int TACK_BIT = 4;
    localparam int TIP_BIT  = 5;
    localparam int DIR_BIT  = 4;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_SEND = 2'd1,
        HS_RECV = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hte_capture_buf.sv
module hte_capture_buf #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          clear,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt_q;

    assign full    = (cnt_q == CW'(DEPTH));
    assign count   = cnt_q;
    assign rd_byte = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[cnt_q[AW-1:0]] <= push_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/hte_response_buf.sv
module hte_response_buf #(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_byte,
    input  logic          load,
    input  logic [LW-1:0] load_len,
    input  logic          pop,
    output logic          pending,
    output logic          last,
    output logic [7:0]    head_byte,
    output logic [LW-1:0] index,
    output logic [LW-1:0] size
);
    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] idx_q, size_q;
    logic [LW-1:0] eff_idx, eff_size;

    // A commit in this cycle is visible to the evaluation of the same cycle.
    assign eff_idx   = load ? '0 : idx_q;
    assign eff_size  = load ? load_len : size_q;
    assign pending   = (eff_idx < eff_size);
    assign last      = ((eff_idx + LW'(1)) >= eff_size);
    assign head_byte = mem[eff_idx[AW-1:0]];
    assign index     = idx_q;
    assign size      = size_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            size_q <= '0;
        end else begin
            if (load) begin
                size_q <= load_len;
            end
            if (pop && pending) begin
                idx_q <= eff_idx + LW'(1);
            end else if (load) begin
                idx_q <= '0;
            end
        end
    end
endmodule

// File: rtl/hte_handshake_fsm.sv
module hte_handshake_fsm
    import hte_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic tip_new,
    input  logic tack_new,
    input  logic dir_out,
    input  logic cap_full,
    input  logic cap_nonempty,
    input  logic rsp_pending,
    input  logic rsp_last,
    output logic cap_push,
    output logic cap_clear,
    output logic rsp_pop,
    output logic treq_hi,
    output logic treq_lo,
    output logic flag_set,
    output logic pkt_done
);
    hs_state_e state_q, state_d;
    logic      last_tack_q;
    logic      pair_changed;

    // Leaving idle always changes TIP, so the pair differs then as well.
    assign pair_changed = (state_q == HS_IDLE) || (tack_new != last_tack_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= HS_RECV;
            last_tack_q <= 1'b0;
        end else if (eval) begin
            state_q     <= state_d;
            last_tack_q <= tack_new;
        end
    end

    always_comb begin
        if (tip_new)      state_d = HS_IDLE;
        else if (dir_out) state_d = HS_SEND;
        else              state_d = HS_RECV;
    end

    always_comb begin
        cap_push  = 1'b0;
        cap_clear = 1'b0;
        rsp_pop   = 1'b0;
        treq_hi   = 1'b0;
        treq_lo   = 1'b0;
        flag_set  = 1'b0;
        pkt_done  = 1'b0;
        if (eval) begin
            if (!tip_new) begin
                if (dir_out) begin
                    if (pair_changed && !cap_full) begin
                        cap_push = 1'b1;
                        flag_set = 1'b1;
                    end
                end else if (rsp_pending && pair_changed) begin
                    rsp_pop  = 1'b1;
                    flag_set = 1'b1;
                    treq_hi  = rsp_last;
                end
            end else begin
                unique case (state_q)
                    HS_IDLE: begin
                        if (tack_new != last_tack_q) begin
                            treq_hi  = tack_new;
                            treq_lo  = !tack_new;
                            flag_set = 1'b1;
                        end else begin
                            treq_lo = rsp_pending;
                        end
                    end
                    HS_SEND, HS_RECV: begin
                        flag_set  = 1'b1;
                        pkt_done  = cap_nonempty;
                        cap_clear = 1'b1;
                        treq_lo   = rsp_pending;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/hte_engine.sv
module hte_engine
    import hte_pkg::*;
#(
    parameter int  CAP_DEPTH = 16,
    parameter int  RSP_DEPTH = 128,
    localparam int CAP_AW    = $clog2(CAP_DEPTH),
    localparam int CNT_W     = $clog2(CAP_DEPTH + 1),
    localparam int RSP_AW    = $clog2(RSP_DEPTH),
    localparam int LEN_W     = $clog2(RSP_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pb_wr_en,
    input  logic [7:0]        pb_wr_data,
    output logic [7:0]        pb_q,
    input  logic              ctl_wr_en,
    input  logic [7:0]        ctl_wr_data,
    output logic [7:0]        ctl_q,
    input  logic              sd_wr_en,
    input  logic [7:0]        sd_wr_data,
    output logic [7:0]        sd_q,
    input  logic              shift_clr,
    output logic              shift_flag,
    input  logic              rsp_wr_en,
    input  logic [RSP_AW-1:0] rsp_wr_addr,
    input  logic [7:0]        rsp_wr_data,
    input  logic              rsp_load,
    input  logic [LEN_W-1:0]  rsp_len,
    input  logic [CAP_AW-1:0] cap_rd_addr,
    output logic [7:0]        cap_rd_data,
    output logic              pkt_valid,
    output logic [CNT_W-1:0]  pkt_len
);
    logic [7:0]       pb_r, ctl_r, sd_r;
    logic [7:0]       pb_w, ctl_w, pb_nxt;
    logic             flag_r, pkt_valid_r;
    logic [CNT_W-1:0] pkt_len_r;
    logic             eval;
    logic             cap_push, cap_clear, cap_full;
    logic [CNT_W-1:0] cap_cnt;
    logic             rsp_pop, rsp_pending, rsp_last;
    logic [7:0]       rsp_head;
    logic [LEN_W-1:0] rsp_idx, rsp_size;
    logic             treq_hi, treq_lo, flag_set, pkt_done;

    assign eval  = pb_wr_en | ctl_wr_en | rsp_load;
    assign pb_w  = pb_wr_en  ? pb_wr_data  : pb_r;
    assign ctl_w = ctl_wr_en ? ctl_wr_data : ctl_r;

    always_comb begin
        pb_nxt = pb_w;
        if (treq_hi)      pb_nxt[TREQ_BIT] = 1'b1;
        else if (treq_lo) pb_nxt[TREQ_BIT] = 1'b0;
    end

    hte_handshake_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .eval         (eval),
        .tip_new      (pb_w[TIP_BIT]),
        .tack_new     (pb_w[TACK_BIT]),
        .dir_out      (ctl_w[DIR_BIT]),
        .cap_full     (cap_full),
        .cap_nonempty (cap_cnt != '0),
        .rsp_pending  (rsp_pending),
        .rsp_last     (rsp_last),
        .cap_push     (cap_push),
        .cap_clear    (cap_clear),
        .rsp_pop      (rsp_pop),
        .treq_hi      (treq_hi),
        .treq_lo      (treq_lo),
        .flag_set     (flag_set),
        .pkt_done     (pkt_done)
    );

    hte_capture_buf #(.DEPTH(CAP_DEPTH)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cap_push),
        .push_byte (sd_r),
        .clear     (cap_clear),
        .rd_addr   (cap_rd_addr),
        .rd_byte   (cap_rd_data),
        .count     (cap_cnt),
        .full      (cap_full)
    );

    hte_response_buf #(.DEPTH(RSP_DEPTH)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (rsp_wr_en),
        .wr_addr   (rsp_wr_addr),
        .wr_byte   (rsp_wr_data),
        .load      (rsp_load),
        .load_len  (rsp_len),
        .pop       (rsp_pop),
        .pending   (rsp_pending),
        .last      (rsp_last),
        .head_byte (rsp_head),
        .index     (rsp_idx),
        .size      (rsp_size)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb_r        <= '0;
            ctl_r       <= '0;
            sd_r        <= '0;
            flag_r      <= 1'b0;
            pkt_valid_r <= 1'b0;
            pkt_len_r   <= '0;
        end else begin
            pb_r        <= pb_nxt;
            ctl_r       <= ctl_w;
            if (rsp_pop)       sd_r <= rsp_head;
            else if (sd_wr_en) sd_r <= sd_wr_data;
            flag_r      <= (flag_r & ~shift_clr) | flag_set | rsp_load;
            pkt_valid_r <= pkt_done;
            if (pkt_done) pkt_len_r <= cap_cnt;
        end
    end

    assign pb_q       = pb_r;
    assign ctl_q      = ctl_r;
    assign sd_q       = sd_r;
    assign shift_flag = flag_r;
    assign pkt_valid  = pkt_valid_r;
    assign pkt_len    = pkt_len_r;
endmodule

// File: rtl/hte_engine_chk.sv
module hte_engine_chk #(
    parameter int  CAP_DEPTH = 16,
    parameter int  RSP_DEPTH = 128,
    localparam int CNT_W     = $clog2(CAP_DEPTH + 1),
    localparam int LEN_W     = $clog2(RSP_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eval,
    input logic [7:0]       pb_q,
    input logic             shift_flag,
    input logic             pkt_valid,
    input logic [CNT_W-1:0] pkt_len,
    input logic [CNT_W-1:0] cap_cnt,
    input logic [LEN_W-1:0] rsp_idx,
    input logic [LEN_W-1:0] rsp_size
);
    assert_cap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_cnt <= CNT_W'(CAP_DEPTH));

    assert_pkt_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0) && pb_q[5] && (cap_cnt == '0));

    assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_flag) |-> $past(eval));

    assert_pb_on_eval_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pb_q) |-> $past(eval));

    assert_rsp_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_idx <= rsp_size);
endmodule

bind hte_engine hte_engine_chk #(.CAP_DEPTH(CAP_DEPTH), .RSP_DEPTH(RSP_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval       (eval),
    .pb_q       (pb_q),
    .shift_flag (shift_flag),
    .pkt_valid  (pkt_valid),
    .pkt_len    (pkt_len),
    .cap_cnt    (cap_cnt),
    .rsp_idx    (rsp_idx),
    .rsp_size   (rsp_size)
);

// File: tb/hte_engine_tb.sv
module hte_engine_tb;
    localparam int CAP_DEPTH = 16;
    localparam int RSP_DEPTH = 128;
    localparam int CAP_AW    = $clog2(CAP_DEPTH);
    localparam int CNT_W     = $clog2(CAP_DEPTH + 1);
    localparam int RSP_AW    = $clog2(RSP_DEPTH);
    localparam int LEN_W     = $clog2(RSP_DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pb_wr_en = 1'b0, ctl_wr_en = 1'b0, sd_wr_en = 1'b0;
    logic [7:0] pb_wr_data = '0, ctl_wr_data = '0, sd_wr_data = '0;
    logic shift_clr = 1'b0, rsp_wr_en = 1'b0, rsp_load = 1'b0;
    logic [RSP_AW-1:0] rsp_wr_addr = '0;
    logic [7:0] rsp_wr_data = '0;
    logic [LEN_W-1:0] rsp_len = '0;
    logic [CAP_AW-1:0] cap_rd_addr = '0;
    logic [7:0] pb_q, ctl_q, sd_q, cap_rd_data;
    logic shift_flag, pkt_valid;
    logic [CNT_W-1:0] pkt_len;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hte_engine #(.CAP_DEPTH(CAP_DEPTH), .RSP_DEPTH(RSP_DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pb_wr_en(pb_wr_en), .pb_wr_data(pb_wr_data), .pb_q(pb_q),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_q(ctl_q),
        .sd_wr_en(sd_wr_en), .sd_wr_data(sd_wr_data), .sd_q(sd_q),
        .shift_clr(shift_clr), .shift_flag(shift_flag),
        .rsp_wr_en(rsp_wr_en), .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data),
        .rsp_load(rsp_load), .rsp_len(rsp_len),
        .cap_rd_addr(cap_rd_addr), .cap_rd_data(cap_rd_data),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Each write is held for one clock edge; results are sampled at the next negedge.
    task automatic pb_write(input logic [7:0] v, input logic clr = 1'b0);
        @(negedge clk);
        pb_wr_en = 1'b1; pb_wr_data = v; shift_clr = clr;
        @(negedge clk);
        pb_wr_en = 1'b0; shift_clr = 1'b0;
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = v;
        @(negedge clk); ctl_wr_en = 1'b0;
    endtask

    task automatic sd_write(input logic [7:0] v);
        @(negedge clk); sd_wr_en = 1'b1; sd_wr_data = v;
        @(negedge clk); sd_wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); shift_clr = 1'b1;
        @(negedge clk); shift_clr = 1'b0;
    endtask

    task automatic rsp_put(input int a, input logic [7:0] v);
        @(negedge clk); rsp_wr_en = 1'b1; rsp_wr_addr = RSP_AW'(a); rsp_wr_data = v;
        @(negedge clk); rsp_wr_en = 1'b0;
    endtask

    task automatic rsp_commit(input int n);
        @(negedge clk); rsp_load = 1'b1; rsp_len = LEN_W'(n);
        @(negedge clk); rsp_load = 1'b0;
    endtask

    task automatic cap_peek(input int a, output logic [7:0] v);
        cap_rd_addr = CAP_AW'(a);
        #1 v = cap_rd_data;
    endtask

    task automatic test_reset();
        chk("R1 pb_q", pb_q, 0);
        chk("R1 ctl_q", ctl_q, 0);
        chk("R1 sd_q", sd_q, 0);
        chk("R1 shift_flag", shift_flag, 0);
        chk("R1 pkt_valid", pkt_valid, 0);
    endtask

    task automatic test_host_send();
        logic [7:0] b;
        ctl_write(8'h10);
        pb_write(8'h30);
        chk("R7 end with empty capture sets flag", shift_flag, 1);
        chk("R7 no strobe on empty capture", pkt_valid, 0);
        clear_flag();
        chk("R10 clear", shift_flag, 0);
        sd_write(8'hA1);
        pb_write(8'h10);
        chk("R2 R3 first byte flag", shift_flag, 1);
        clear_flag();
        sd_write(8'hB2);
        pb_write(8'h00);
        chk("R3 second byte flag", shift_flag, 1);
        clear_flag();
        pb_write(8'h00);
        chk("R3 unchanged pair no flag", shift_flag, 0);
        pb_write(8'h30);
        chk("R7 strobe", pkt_valid, 1);
        chk("R3 R7 length 2 (unchanged pair captured nothing)", pkt_len, 2);
        chk("R7 flag at end", shift_flag, 1);
        @(negedge clk);
        chk("R7 strobe one cycle", pkt_valid, 0);
        cap_peek(0, b); chk("R3 byte0", b, 8'hA1);
        cap_peek(1, b); chk("R3 byte1", b, 8'hB2);
        clear_flag();
    endtask

    task automatic test_overflow();
        logic [7:0] b;
        for (int i = 0; i < CAP_DEPTH + 1; i++) begin
            sd_write(8'(8'h40 + i));
            if (i == CAP_DEPTH) clear_flag();
            pb_write((i % 2 == 0) ? 8'h10 : 8'h00);
        end
        chk("R4 dropped byte sets no flag", shift_flag, 0);
        pb_write(8'h30);
        chk("R4 strobe when full", pkt_valid, 1);
        chk("R4 length capped", pkt_len, CAP_DEPTH);
        cap_peek(CAP_DEPTH - 1, b);
        chk("R4 last kept byte", b, 8'h40 + CAP_DEPTH - 1);
        clear_flag();
    endtask

    task automatic test_sync();
        pb_write(8'h20, 1'b1);
        chk("R6 TREQ follows TACK low", pb_q, 8'h20);
        chk("R10 set wins over clear", shift_flag, 1);
        clear_flag();
        pb_write(8'h30);
        chk("R6 TREQ follows TACK high", pb_q, 8'h38);
        chk("R6 flag", shift_flag, 1);
        clear_flag();
    endtask

    task automatic test_device_send();
        ctl_write(8'h00);
        pb_write(8'h38);
        chk("R8 no pending keeps TREQ high", pb_q, 8'h38);
        rsp_put(0, 8'h11);
        rsp_put(1, 8'h22);
        rsp_put(2, 8'h33);
        rsp_commit(3);
        chk("R8 R9 pending pulls TREQ low", pb_q, 8'h30);
        chk("R9 commit sets flag", shift_flag, 1);
        clear_flag();
        pb_write(8'h10);
        chk("R5 byte0", sd_q, 8'h11);
        chk("R5 flag", shift_flag, 1);
        pb_write(8'h00);
        chk("R5 byte1", sd_q, 8'h22);
        chk("R5 TREQ low before last", pb_q, 8'h00);
        pb_write(8'h10);
        chk("R5 byte2", sd_q, 8'h33);
        chk("R5 TREQ released on last", pb_q, 8'h18);
        clear_flag();
        pb_write(8'h00);
        chk("R5 empty keeps data", sd_q, 8'h33);
        chk("R5 empty no flag", shift_flag, 0);
        pb_write(8'h30);
        chk("R7 end flag", shift_flag, 1);
        chk("R7 no strobe in device direction", pkt_valid, 0);
        chk("R8 nothing pending", pb_q, 8'h30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_host_send();
        test_overflow();
        test_sync();
        test_device_send();
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule